// File: doc/BRIEF.md
# Path-Compressed Trie Longest-Prefix Lookup Engine

This block resolves the longest matching prefix of a fixed-width address by walking a path-compressed binary trie kept in a small node store inside the block. Each node names the address bit to test next. This lets chains of single-child nodes be skipped. Each node also carries a prefix bitstring with a length, an optional next hop, and two child indices. A start pulse launches a walk from the root, which sits at node index 1. The engine reads one node per clock. When a node carries a next hop and its bitstring agrees with the address over the stored length, that hop becomes the best so far. The walk then follows the child picked by the tested bit. It stops at a null child and reports the best hop, or a miss, with a one-cycle done pulse.

The walk never backtracks. Every prefix that matches the address lies on the path that the bit tests select, and each such node confirms its own prefix by comparison. So the deepest confirmed hop is the longest match. Software or a build engine outside this block fills the node store through a write-only load port. Building the trie is not part of this block.

Top module: `pct_lookup`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `busy`, `done` and `hit` are low and `hop` is zero.
- R2: A load strobe writes all fields of the node at `ld_idx` in one cycle. Later walks read these values.
- R3: At a node with bit position p, the engine tests address bit p, where position 1 is the most significant bit. A 0 follows the left child and a 1 follows the right child.
- R4: A node's next hop becomes the best candidate only if its hop-valid flag is set and the top `len` address bits equal the top `len` bits of its stored bitstring. The stored bitstring is left-aligned in an `ADDR_W` field, and a length of 0 matches every address. A deeper accepted node replaces an earlier candidate.
- R5: Child index 0 means null, and node 1 is the root. The walk ends on the cycle that reads a node whose selected child is null. `done` rises after that edge for exactly one cycle. The number of cycles from the start edge to `done` equals the number of nodes visited.
- R6: If no node along the path is accepted, `done` comes with `hit` low and `hop` equal to 0. Otherwise `hit` is high and `hop` holds the deepest accepted next hop.
- R7: A start pulse while `busy` is high is ignored. The running walk keeps its latched address and its result.
- R8: A walk reads at most `ADDR_W` nodes. If the table has a cycle, the walk is cut off after `ADDR_W` reads and reports the best hop found up to that point.
- R9: `busy` is high from the edge that accepts a start until the edge that raises `done`. It is low while `done` is high.
- R10: `hit` and `hop` change only on the edge that raises `done`. Between walks they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a walk when idle |
| addr_in | input | ADDR_W | Address to resolve, sampled with start |
| ld_en | input | 1 | Node write strobe |
| ld_idx | input | PTR_W | Node index to write |
| ld_pos | input | POS_W | Bit position tested at the node (1 = MSB) |
| ld_len | input | POS_W | Stored prefix length in bits |
| ld_bits | input | ADDR_W | Stored prefix bits, left-aligned |
| ld_hop_vld | input | 1 | Node ends a prefix |
| ld_hop | input | HOP_W | Next hop of that prefix |
| ld_left | input | PTR_W | Child for a 0 bit (0 = null) |
| ld_right | input | PTR_W | Child for a 1 bit (0 = null) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | A prefix matched |
| hop | output | HOP_W | Longest-match next hop, 0 on a miss |

## Verification
The hardest case to reach is a node that the bit tests select but whose stored prefix disagrees with the address, because the skipped bits differ. The engine must then keep the shallower candidate and must not backtrack. The bench loads a six-node table for four overlapping prefixes, with and without a default route at the root. It sweeps all 256 addresses and compares hit, hop and walk length against a reference computed arithmetically. Addresses such as 10111xxx send the walk through two non-matching nodes whose skipped bit differs from the stored prefix. A self-looping root drives the depth cut-off, and a second start issued mid-walk tests that the latched address is held.

// File: rtl/pct_pkg.sv
// Shared definitions for the path-compressed trie lookup engine.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pct_pkg;
    // Walk controller states
    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_WALK = 1'b1
    } walk_st_e;

    // Index of the root node; index 0 encodes a null child
    localparam int ROOT_IDX = 1;
endpackage

// File: rtl/pct_node_ram.sv
// Node store: one synchronous write port, one combinational read port.
// Assumes the writer never loads index 0 as a real child target.
module pct_node_ram #(
    parameter int ADDR_W = 8,
    parameter int NODES  = 16,
    parameter int HOP_W  = 4,
    localparam int PTR_W = $clog2(NODES),
    localparam int POS_W = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [POS_W-1:0]  wr_pos,
    input  logic [POS_W-1:0]  wr_len,
    input  logic [ADDR_W-1:0] wr_bits,
    input  logic              wr_hv,
    input  logic [HOP_W-1:0]  wr_hop,
    input  logic [PTR_W-1:0]  wr_left,
    input  logic [PTR_W-1:0]  wr_right,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [POS_W-1:0]  rd_pos,
    output logic [POS_W-1:0]  rd_len,
    output logic [ADDR_W-1:0] rd_bits,
    output logic              rd_hv,
    output logic [HOP_W-1:0]  rd_hop,
    output logic [PTR_W-1:0]  rd_left,
    output logic [PTR_W-1:0]  rd_right
);
    logic [POS_W-1:0]  pos_m   [NODES];
    logic [POS_W-1:0]  len_m   [NODES];
    logic [ADDR_W-1:0] bits_m  [NODES];
    logic              hv_m    [NODES];
    logic [HOP_W-1:0]  hop_m   [NODES];
    logic [PTR_W-1:0]  left_m  [NODES];
    logic [PTR_W-1:0]  right_m [NODES];

    // Write every field of the addressed node in one cycle
    always_ff @(posedge clk) begin
        if (wr_en) begin
            pos_m[wr_idx]   <= wr_pos;
            len_m[wr_idx]   <= wr_len;
            bits_m[wr_idx]  <= wr_bits;
            hv_m[wr_idx]    <= wr_hv;
            hop_m[wr_idx]   <= wr_hop;
            left_m[wr_idx]  <= wr_left;
            right_m[wr_idx] <= wr_right;
        end
    end

    // Present the node the walker is visiting
    always_comb begin
        rd_pos   = pos_m[rd_idx];
        rd_len   = len_m[rd_idx];
        rd_bits  = bits_m[rd_idx];
        rd_hv    = hv_m[rd_idx];
        rd_hop   = hop_m[rd_idx];
        rd_left  = left_m[rd_idx];
        rd_right = right_m[rd_idx];
    end
endmodule

// File: rtl/pct_node_eval.sv
// Per-node combinational evaluation: picks the tested address bit and
// checks the stored prefix against the address over its length.
// Assumes bit positions count from 1 at the MSB; out-of-range gives 0.
module pct_node_eval #(
    parameter int ADDR_W = 8,
    localparam int POS_W = $clog2(ADDR_W + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [POS_W-1:0]  pos,
    input  logic [POS_W-1:0]  len,
    input  logic [ADDR_W-1:0] bits,
    output logic              go_right,
    output logic              pfx_match
);
    logic [ADDR_W-1:0] mask;

    // Bit i (LSB-indexed) sits at 1-based position ADDR_W-i; keep it if inside the prefix
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign mask[i] = (POS_W'(ADDR_W - i) <= len);
    end

    // Select the address bit named by the node's bit position
    always_comb begin
        go_right = 1'b0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (pos == POS_W'(ADDR_W - i)) go_right = addr[i];
        end
    end

    // Prefix agrees when no masked bit differs
    assign pfx_match = (((addr ^ bits) & mask) == '0);
endmodule

// File: rtl/pct_walk_ctl.sv
// Walk controller: accepts a start when idle, steps one node per cycle,
// keeps the deepest accepted next hop, and ends on a null child or after
// ADDR_W node reads. Assumes node data for cur_idx is valid in the same cycle.
module pct_walk_ctl
    import pct_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NODES  = 16,
    parameter int HOP_W  = 4,
    localparam int PTR_W = $clog2(NODES),
    localparam int POS_W = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              nd_hv,
    input  logic [HOP_W-1:0]  nd_hop,
    input  logic [PTR_W-1:0]  nd_left,
    input  logic [PTR_W-1:0]  nd_right,
    input  logic              go_right,
    input  logic              pfx_match,
    output logic [PTR_W-1:0]  cur_idx,
    output logic [ADDR_W-1:0] addr_q,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic [HOP_W-1:0]  hop
);
    walk_st_e          state;
    logic [POS_W-1:0]  visits;
    logic              best_v;
    logic [HOP_W-1:0]  best_h;
    logic              take;
    logic              nb_v;
    logic [HOP_W-1:0]  nb_h;
    logic [PTR_W-1:0]  nxt;
    logic              last;

    // Candidate update and next-step decision for the node being read
    always_comb begin
        take = nd_hv && pfx_match;
        nb_v = take || best_v;
        nb_h = take ? nd_hop : best_h;
        nxt  = go_right ? nd_right : nd_left;
        last = (nxt == '0) || (visits == POS_W'(ADDR_W - 1));
    end

    // State, walk position, best candidate and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= WS_IDLE;
            cur_idx <= '0;
            addr_q  <= '0;
            visits  <= '0;
            best_v  <= 1'b0;
            best_h  <= '0;
            done    <= 1'b0;
            hit     <= 1'b0;
            hop     <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                WS_IDLE: begin
                    if (start) begin
                        state   <= WS_WALK;
                        cur_idx <= PTR_W'(ROOT_IDX);
                        addr_q  <= addr_in;
                        visits  <= '0;
                        best_v  <= 1'b0;
                        best_h  <= '0;
                    end
                end
                WS_WALK: begin
                    best_v <= nb_v;
                    best_h <= nb_h;
                    if (last) begin
                        state <= WS_IDLE;
                        done  <= 1'b1;
                        hit   <= nb_v;
                        hop   <= nb_v ? nb_h : '0;
                    end else begin
                        cur_idx <= nxt;
                        visits  <= visits + 1'b1;
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    assign busy = (state == WS_WALK);
endmodule

// File: rtl/pct_lookup.sv
// Top of the path-compressed trie lookup engine: node store, node
// evaluation and walk controller. Assumes the loaded table is a valid
// path-compressed trie rooted at node 1 with index 0 as null.
module pct_lookup #(
    parameter int ADDR_W = 8,
    parameter int NODES  = 16,
    parameter int HOP_W  = 4,
    localparam int PTR_W = $clog2(NODES),
    localparam int POS_W = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ld_en,
    input  logic [PTR_W-1:0]  ld_idx,
    input  logic [POS_W-1:0]  ld_pos,
    input  logic [POS_W-1:0]  ld_len,
    input  logic [ADDR_W-1:0] ld_bits,
    input  logic              ld_hop_vld,
    input  logic [HOP_W-1:0]  ld_hop,
    input  logic [PTR_W-1:0]  ld_left,
    input  logic [PTR_W-1:0]  ld_right,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic [HOP_W-1:0]  hop
);
    logic [PTR_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] addr_q;
    logic [POS_W-1:0]  nd_pos;
    logic [POS_W-1:0]  nd_len;
    logic [ADDR_W-1:0] nd_bits;
    logic              nd_hv;
    logic [HOP_W-1:0]  nd_hop;
    logic [PTR_W-1:0]  nd_left;
    logic [PTR_W-1:0]  nd_right;
    logic              go_right;
    logic              pfx_match;

    pct_node_ram #(.ADDR_W(ADDR_W), .NODES(NODES), .HOP_W(HOP_W)) u_ram (
        .clk      (clk),
        .wr_en    (ld_en),
        .wr_idx   (ld_idx),
        .wr_pos   (ld_pos),
        .wr_len   (ld_len),
        .wr_bits  (ld_bits),
        .wr_hv    (ld_hop_vld),
        .wr_hop   (ld_hop),
        .wr_left  (ld_left),
        .wr_right (ld_right),
        .rd_idx   (cur_idx),
        .rd_pos   (nd_pos),
        .rd_len   (nd_len),
        .rd_bits  (nd_bits),
        .rd_hv    (nd_hv),
        .rd_hop   (nd_hop),
        .rd_left  (nd_left),
        .rd_right (nd_right)
    );

    pct_node_eval #(.ADDR_W(ADDR_W)) u_eval (
        .addr      (addr_q),
        .pos       (nd_pos),
        .len       (nd_len),
        .bits      (nd_bits),
        .go_right  (go_right),
        .pfx_match (pfx_match)
    );

    pct_walk_ctl #(.ADDR_W(ADDR_W), .NODES(NODES), .HOP_W(HOP_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .addr_in   (addr_in),
        .nd_hv     (nd_hv),
        .nd_hop    (nd_hop),
        .nd_left   (nd_left),
        .nd_right  (nd_right),
        .go_right  (go_right),
        .pfx_match (pfx_match),
        .cur_idx   (cur_idx),
        .addr_q    (addr_q),
        .busy      (busy),
        .done      (done),
        .hit       (hit),
        .hop       (hop)
    );
endmodule

// File: rtl/pct_lookup_chk.sv
// Protocol checker for pct_lookup, attached by bind. Observes ports and
// the latched walk address; counts busy cycles to bound walk length.
module pct_lookup_chk #(
    parameter int ADDR_W = 8,
    parameter int HOP_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              hit,
    input logic [HOP_W-1:0]  hop,
    input logic [ADDR_W-1:0] addr_q
);
    logic [15:0] busy_cnt;

    // Count consecutive busy cycles of the current walk
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cnt <= '0;
        else                 busy_cnt <= busy_cnt + 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !hit && hop == '0));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (hop == '0));

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(addr_q));

    // R8
    walk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < 16'(ADDR_W)));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable({hit, hop}));
endmodule

bind pct_lookup pct_lookup_chk #(.ADDR_W(ADDR_W), .HOP_W(HOP_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .hit    (hit),
    .hop    (hop),
    .addr_q (addr_q)
);

// File: tb/pct_lookup_test.sv
// Bench for pct_lookup: exhaustive address sweep over a six-node trie,
// with and without a default route, plus cut-off and busy-start cases.
module pct_lookup_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int NODES  = 16;
    localparam int HOP_W  = 4;
    localparam int PTR_W  = $clog2(NODES);
    localparam int POS_W  = $clog2(ADDR_W + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              ld_en = 1'b0;
    logic [PTR_W-1:0]  ld_idx = '0;
    logic [POS_W-1:0]  ld_pos = '0;
    logic [POS_W-1:0]  ld_len = '0;
    logic [ADDR_W-1:0] ld_bits = '0;
    logic              ld_hop_vld = 1'b0;
    logic [HOP_W-1:0]  ld_hop = '0;
    logic [PTR_W-1:0]  ld_left = '0;
    logic [PTR_W-1:0]  ld_right = '0;
    logic              busy, done, hit;
    logic [HOP_W-1:0]  hop;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    pct_lookup #(.ADDR_W(ADDR_W), .NODES(NODES), .HOP_W(HOP_W)) uut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_node(input int idx, input int pos, input int len, input int bits,
                             input bit hv, input int h, input int l, input int r);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = PTR_W'(idx); ld_pos = POS_W'(pos); ld_len = POS_W'(len);
        ld_bits = ADDR_W'(bits); ld_hop_vld = hv; ld_hop = HOP_W'(h);
        ld_left = PTR_W'(l); ld_right = PTR_W'(r);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic clear_ram();
        for (int i = 0; i < NODES; i++) load_node(i, 0, 0, 0, 1'b0, 0, 0, 0);
    endtask

    // R2: trie for 111*->1, 10*->2, 1010*->3, 10101->4; optional default 7 at root
    task automatic load_table(input bit dflt);
        clear_ram();
        load_node(1, 1, 0, 8'h00, dflt, 7, 0, 2);
        load_node(2, 2, 1, 8'h80, 1'b0, 0, 3, 6);
        load_node(3, 3, 2, 8'h80, 1'b1, 2, 0, 4);
        load_node(4, 5, 4, 8'hA0, 1'b1, 3, 0, 5);
        load_node(5, 1, 5, 8'hA8, 1'b1, 4, 0, 0);
        load_node(6, 1, 3, 8'hE0, 1'b1, 1, 0, 0);
    endtask

    function automatic int ref_hop(input logic [7:0] a, input bit dflt);
        int h = dflt ? 7 : 0;
        if (a[7:6] == 2'b10)   h = 2;
        if (a[7:4] == 4'hA)    h = 3;
        if (a[7:3] == 5'h15)   h = 4;
        if (a[7:5] == 3'b111)  h = 1;
        return h;
    endfunction

    function automatic int ref_visits(input logic [7:0] a);
        if (!a[7]) return 1;
        if (a[6])  return 3;
        if (!a[5]) return 3;
        if (!a[3]) return 4;
        return 5;
    endfunction

    // Launch a walk and count cycles until done (sampled at negedges)
    task automatic lookup(input logic [ADDR_W-1:0] a, output int n);
        @(negedge clk);
        start = 1'b1; addr_in = a;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9 busy after start", int'(busy), 1);
        n = 0;
        while (!done && n < 64) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        int eh;
        repeat (3) @(negedge clk);
        // R1
        chk(busy === 1'b0 && done === 1'b0, "R1 reset busy/done", int'({busy, done}), 0);
        chk(hit === 1'b0 && hop === '0, "R1 reset result", int'({hit, hop}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && hit === 1'b0, "R1 after reset", int'({busy, hit}), 0);

        for (int t = 0; t < 2; t++) begin
            load_table(t[0]);
            for (int a = 0; a < 256; a++) begin
                lookup(8'(a), n);
                eh = ref_hop(8'(a), t[0]);
                // R3 R5: path length follows the tested bits
                chk(n == ref_visits(8'(a)), "R5 walk length", n, ref_visits(8'(a)));
                // R4 R6
                chk(hit === (eh != 0), "R6 hit flag", int'(hit), int'(eh != 0));
                chk(int'(hop) == eh, "R4 next hop", int'(hop), eh);
                chk(busy === 1'b0, "R9 idle at done", int'(busy), 0);
                @(negedge clk);
                chk(done === 1'b0, "R5 done one cycle", int'(done), 0);
                chk(int'(hop) == eh, "R10 hop held", int'(hop), eh);
            end
        end

        // R7: second start mid-walk with a different address is ignored
        load_table(1'b0);
        @(negedge clk);
        start = 1'b1; addr_in = 8'hB8;
        @(negedge clk);
        start = 1'b1; addr_in = 8'hE0;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 64) begin
            @(negedge clk);
            n++;
        end
        chk(n == 5, "R7 walk length kept", n, 5);
        chk(int'(hop) == 2, "R7 result of first address", int'(hop), 2);

        // R8: self-looping root is cut off after ADDR_W reads
        clear_ram();
        load_node(1, 1, 0, 8'h00, 1'b1, 5, 1, 1);
        lookup(8'h5A, n);
        chk(n == ADDR_W, "R8 cut-off length", n, ADDR_W);
        chk(hit === 1'b1 && int'(hop) == 5, "R8 cut-off result", int'(hop), 5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule